// File: doc/BRIEF.md
# Duplicated Register File with Nibble Repair

This block is a small register file held twice, as copy A and copy B, for a processor whose data path is itself duplicated. Each entry holds a data word plus one even-parity bit for every 4-bit group of that word. A single write port stores the same word, with freshly computed parity, into both copies. Two operand read ports and one destination-preview read port return both copies side by side, so that each redundant pipeline takes its own copy. The operand ports also raise a per-copy parity flag. The preview port shows an entry's contents before a write in the same cycle replaces them.

A repair operation heals upsets in one entry over two cycles. In the first cycle both copies of the entry are read into stage registers. At the next edge they are written back corrected. For each 4-bit group, the copy whose parity is good overwrites the copy whose parity is bad, so one entry can take some groups from A and others from B. A group that is bad in both copies is left as it is, and the block pulses an uncorrectable flag together with the entry index. A valid flag for each entry is cleared by reset and set by the first write. Parity of an entry is only checked once its flag is set, because storage contents are unknown after reset. A bit-flip input models a single-event upset in one stored bit of one copy.

Top module: `dup_regfile_repair`

## Requirements
- R1: A write stores the data word into both copies with even parity per group: the parity bit of group g equals the XOR of data bits [4g+3:4g]. Operand and preview ports return the stored data of copy A and copy B combinationally.
- R2: Reset clears every valid flag. A write sets the flag of its entry. While an entry's flag is clear, its parity flags read 2'b00.
- R3: Each operand port reports `rdN_perr`, where bit 0 is copy A and bit 1 is copy B. A bit is 1 when the entry is valid and any group in that copy has stored parity different from the XOR of its four data bits.
- R4: In the cycle of a write to an entry, the preview port addressing that entry returns the old contents. From the next cycle it returns the new word.
- R5: `rep_start` samples both copies of `rep_addr` at a clock edge and writes the corrected rows back at the following edge. For each group: if copy A's parity is bad, A's four data bits and parity bit are replaced by B's; otherwise B's are replaced by A's.
- R6: Different groups of one entry may be repaired in opposite directions in a single repair. After it, both copies hold the original word with no parity error.
- R7: When some group is bad in both copies, that group is left unmodified in both copies. `unc_o` is 1 for exactly the cycle between the sampling edge and the write-back edge, with `unc_idx` equal to the entry.
- R8: A write to the repaired entry, either in the start cycle or in the write-back cycle, cancels the repair write-back and the uncorrectable report. The written word is kept.
- R9: A repair of an entry whose valid flag is clear changes nothing and reports no uncorrectable error.
- R10: There is no interlock. `rep_start` may be given on every cycle, so repairs of all entries can run back to back.
- R11: `flip_en` inverts one stored bit of one copy (`flip_copy` 0 = A, 1 = B). The stored row is laid out as data in bits [31:0] and the parity of group g in bit 32+g. The flip applies on top of any write or repair to the same entry at that edge, and flip_bit values of 40 and above do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write both copies |
| wr_addr | input | 5 | Write entry |
| wr_data | input | 32 | Write data |
| rd0_addr | input | 5 | Operand port 0 entry |
| rd0_data_a | output | 32 | Port 0, copy A data |
| rd0_data_b | output | 32 | Port 0, copy B data |
| rd0_perr | output | 2 | Port 0 parity error {B, A} |
| rd1_addr | input | 5 | Operand port 1 entry |
| rd1_data_a | output | 32 | Port 1, copy A data |
| rd1_data_b | output | 32 | Port 1, copy B data |
| rd1_perr | output | 2 | Port 1 parity error {B, A} |
| pv_addr | input | 5 | Preview port entry |
| pv_data_a | output | 32 | Preview, copy A data |
| pv_data_b | output | 32 | Preview, copy B data |
| rep_start | input | 1 | Start a repair of rep_addr |
| rep_addr | input | 5 | Entry to repair |
| flip_en | input | 1 | Upset injection enable |
| flip_copy | input | 1 | Copy to upset (0 = A, 1 = B) |
| flip_addr | input | 5 | Entry to upset |
| flip_bit | input | 6 | Stored bit to invert |
| unc_o | output | 1 | Uncorrectable group found in write-back cycle |
| unc_idx | output | 5 | Entry of the uncorrectable report |

## Verification
Several upset patterns are used, each separating one behaviour from its alternatives:
- A single data-bit flip in one copy shows whether the correct copy was chosen.
- Flips of parity bits alone show that a parity-only fault is repaired without disturbing the data.
- A flip in A in one group and in B in another group shows that the copy is chosen per group and not per entry.
- Flips in the same group of both copies separate the uncorrectable case from a repair.

Writes placed in the start and write-back cycles of a repair, back-to-back repairs of every entry, and a long random mix of writes, upsets and repairs are all compared against a behavioural model every cycle.

// File: rtl/dup_regfile_repair.sv
module dup_regfile_repair #(
  parameter int ENTRIES = 32,
  parameter int DATA_W  = 32,
  parameter int NIB_W   = 4,
  localparam int AW     = $clog2(ENTRIES),
  localparam int GROUPS = DATA_W / NIB_W,
  localparam int ROW_W  = DATA_W + GROUPS,
  localparam int BW     = $clog2(ROW_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd0_addr,
  output logic [DATA_W-1:0] rd0_data_a,
  output logic [DATA_W-1:0] rd0_data_b,
  output logic [1:0]        rd0_perr,
  input  logic [AW-1:0]     rd1_addr,
  output logic [DATA_W-1:0] rd1_data_a,
  output logic [DATA_W-1:0] rd1_data_b,
  output logic [1:0]        rd1_perr,
  input  logic [AW-1:0]     pv_addr,
  output logic [DATA_W-1:0] pv_data_a,
  output logic [DATA_W-1:0] pv_data_b,
  input  logic              rep_start,
  input  logic [AW-1:0]     rep_addr,
  input  logic              flip_en,
  input  logic              flip_copy,
  input  logic [AW-1:0]     flip_addr,
  input  logic [BW-1:0]     flip_bit,
  output logic              unc_o,
  output logic [AW-1:0]     unc_idx
);

  function automatic logic [ROW_W-1:0] encode(input logic [DATA_W-1:0] d);
    logic [GROUPS-1:0] p;
    for (int g = 0; g < GROUPS; g++) p[g] = ^d[g*NIB_W +: NIB_W];
    return {p, d};
  endfunction

  function automatic logic [GROUPS-1:0] bad(input logic [ROW_W-1:0] r);
    logic [GROUPS-1:0] b;
    for (int g = 0; g < GROUPS; g++) b[g] = (^r[g*NIB_W +: NIB_W]) ^ r[DATA_W+g];
    return b;
  endfunction

  logic [ROW_W-1:0] mem_a [ENTRIES];
  logic [ROW_W-1:0] mem_b [ENTRIES];
  logic [ROW_W-1:0] nxt_a [ENTRIES];
  logic [ROW_W-1:0] nxt_b [ENTRIES];
  logic [ENTRIES-1:0] vld;

  logic              q_busy;
  logic [AW-1:0]     q_idx;
  logic [ROW_W-1:0]  q_a, q_b, fix_a, fix_b;
  logic [GROUPS-1:0] bad_a, bad_b, both;
  logic              rep_we;
  logic [ROW_W-1:0]  wr_row, flip_mask;

  assign rd0_data_a = mem_a[rd0_addr][DATA_W-1:0];
  assign rd0_data_b = mem_b[rd0_addr][DATA_W-1:0];
  assign rd1_data_a = mem_a[rd1_addr][DATA_W-1:0];
  assign rd1_data_b = mem_b[rd1_addr][DATA_W-1:0];
  assign pv_data_a  = mem_a[pv_addr][DATA_W-1:0];
  assign pv_data_b  = mem_b[pv_addr][DATA_W-1:0];
  assign rd0_perr   = vld[rd0_addr] ? {|bad(mem_b[rd0_addr]), |bad(mem_a[rd0_addr])} : 2'b00;
  assign rd1_perr   = vld[rd1_addr] ? {|bad(mem_b[rd1_addr]), |bad(mem_a[rd1_addr])} : 2'b00;

  assign wr_row    = encode(wr_data);
  assign flip_mask = ROW_W'(1) << flip_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) q_busy <= 1'b0;
    else        q_busy <= rep_start && !(wr_en && wr_addr == rep_addr);
  end

  always_ff @(posedge clk) begin
    q_idx <= rep_addr;
    q_a   <= mem_a[rep_addr];
    q_b   <= mem_b[rep_addr];
  end

  assign bad_a = bad(q_a);
  assign bad_b = bad(q_b);
  assign both  = bad_a & bad_b;

  always_comb begin
    fix_a = q_a;
    fix_b = q_b;
    for (int g = 0; g < GROUPS; g++) begin
      if (!both[g]) begin
        if (bad_a[g]) begin
          fix_a[g*NIB_W +: NIB_W] = q_b[g*NIB_W +: NIB_W];
          fix_a[DATA_W+g]         = q_b[DATA_W+g];
        end else begin
          fix_b[g*NIB_W +: NIB_W] = q_a[g*NIB_W +: NIB_W];
          fix_b[DATA_W+g]         = q_a[DATA_W+g];
        end
      end
    end
  end

  assign rep_we  = q_busy && vld[q_idx] && !(wr_en && wr_addr == q_idx);
  assign unc_o   = rep_we && (|both);
  assign unc_idx = q_idx;

  always_comb begin
    nxt_a = mem_a;
    nxt_b = mem_b;
    if (rep_we) begin
      nxt_a[q_idx] = fix_a;
      nxt_b[q_idx] = fix_b;
    end
    if (wr_en) begin
      nxt_a[wr_addr] = wr_row;
      nxt_b[wr_addr] = wr_row;
    end
    if (flip_en) begin
      if (flip_copy) nxt_b[flip_addr] = nxt_b[flip_addr] ^ flip_mask;
      else           nxt_a[flip_addr] = nxt_a[flip_addr] ^ flip_mask;
    end
  end

  always_ff @(posedge clk) begin
    mem_a <= nxt_a;
    mem_b <= nxt_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     vld <= '0;
    else if (wr_en) vld[wr_addr] <= 1'b1;
  end

  // R2
  valid_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld[$past(wr_addr)]);

  // R1
  copies_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !flip_en |=> (mem_a[$past(wr_addr)] == mem_b[$past(wr_addr)])
                          && (bad(mem_a[$past(wr_addr)]) == '0));

  // R5
  repair_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rep_we && !unc_o && !(flip_en && flip_addr == q_idx) |=>
      (bad(mem_a[$past(q_idx)]) == '0) && (bad(mem_b[$past(q_idx)]) == '0));

  // R7
  unc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unc_o && !(flip_en && flip_addr == q_idx) |=>
      (bad(mem_a[$past(q_idx)]) & bad(mem_b[$past(q_idx)])) != '0);

endmodule

// File: tb/dup_regfile_repair_bench.sv
module dup_regfile_repair_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0, rep_start = 0, flip_en = 0, flip_copy = 0;
  logic [4:0] wr_addr = 0, rd0_addr = 0, rd1_addr = 0, pv_addr = 0, rep_addr = 0, flip_addr = 0;
  logic [31:0] wr_data = 0;
  logic [5:0] flip_bit = 0;
  logic [31:0] rd0_data_a, rd0_data_b, rd1_data_a, rd1_data_b, pv_data_a, pv_data_b;
  logic [1:0] rd0_perr, rd1_perr;
  logic unc_o;
  logic [4:0] unc_idx;

  always #5 clk = ~clk;

  dup_regfile_repair u_dup_regfile_repair (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd0_addr(rd0_addr), .rd0_data_a(rd0_data_a), .rd0_data_b(rd0_data_b), .rd0_perr(rd0_perr),
    .rd1_addr(rd1_addr), .rd1_data_a(rd1_data_a), .rd1_data_b(rd1_data_b), .rd1_perr(rd1_perr),
    .pv_addr(pv_addr), .pv_data_a(pv_data_a), .pv_data_b(pv_data_b),
    .rep_start(rep_start), .rep_addr(rep_addr), .flip_en(flip_en), .flip_copy(flip_copy),
    .flip_addr(flip_addr), .flip_bit(flip_bit), .unc_o(unc_o), .unc_idx(unc_idx));

  int checks = 0, fails = 0, cycles = 0;
  bit chk_on = 0;
  string phase = "R2";

  logic [39:0] ma [32];
  logic [39:0] mb [32];
  bit mv [32];
  bit pb = 0;
  int pidx = 0;
  logic [39:0] pa, pq, cap_a, cap_b;
  logic [31:0] dv [32];

  function automatic logic [39:0] enc(logic [31:0] d);
    logic [39:0] r;
    r[31:0] = d;
    for (int g = 0; g < 8; g++) begin
      int n = 0;
      for (int b = 0; b < 4; b++) n += int'(d[4*g+b]);
      r[32+g] = n[0];
    end
    return r;
  endfunction

  function automatic logic [7:0] badg(logic [39:0] r);
    logic [7:0] v;
    for (int g = 0; g < 8; g++) begin
      int n = int'(r[32+g]);
      for (int b = 0; b < 4; b++) n += int'(r[4*g+b]);
      v[g] = n[0];
    end
    return v;
  endfunction

  task automatic chk(string tag, logic [39:0] got, logic [39:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // reference model, one update per clock
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < 32; e++) mv[e] = 0;
      pb = 0;
    end else begin
      cap_a = ma[rep_addr];
      cap_b = mb[rep_addr];
      if (pb && mv[pidx] && !(wr_en && wr_addr == 5'(pidx))) begin
        logic [7:0] ba, bb;
        ba = badg(pa); bb = badg(pq);
        for (int g = 0; g < 8; g++) begin
          if (ba[g] && bb[g]) continue;
          for (int b = 0; b < 4; b++) begin
            if (ba[g]) pa[4*g+b] = pq[4*g+b]; else pq[4*g+b] = pa[4*g+b];
          end
          if (ba[g]) pa[32+g] = pq[32+g]; else pq[32+g] = pa[32+g];
        end
        ma[pidx] = pa; mb[pidx] = pq;
      end
      if (wr_en) begin
        ma[wr_addr] = enc(wr_data); mb[wr_addr] = enc(wr_data); mv[wr_addr] = 1;
      end
      if (flip_en && flip_bit < 40) begin
        if (flip_copy) mb[flip_addr][flip_bit] = ~mb[flip_addr][flip_bit];
        else           ma[flip_addr][flip_bit] = ~ma[flip_addr][flip_bit];
      end
      pb = rep_start && !(wr_en && wr_addr == rep_addr);
      pidx = int'(rep_addr); pa = cap_a; pq = cap_b;
    end
  end

  function automatic logic [1:0] exp_perr(logic [4:0] a);
    if (!mv[a]) return 2'b00;
    return {|badg(mb[a]), |badg(ma[a])};
  endfunction

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (chk_on) begin
      bit eu;
      eu = pb && mv[pidx] && !(wr_en && wr_addr == 5'(pidx)) && ((badg(pa) & badg(pq)) != 0);
      if (mv[rd0_addr]) begin
        chk({phase, " R1 rd0 A"}, 40'(rd0_data_a), 40'(ma[rd0_addr][31:0]));
        chk({phase, " R1 rd0 B"}, 40'(rd0_data_b), 40'(mb[rd0_addr][31:0]));
      end
      if (mv[rd1_addr]) begin
        chk({phase, " R1 rd1 A"}, 40'(rd1_data_a), 40'(ma[rd1_addr][31:0]));
        chk({phase, " R1 rd1 B"}, 40'(rd1_data_b), 40'(mb[rd1_addr][31:0]));
      end
      if (mv[pv_addr]) begin
        chk({phase, " R4 pv A"}, 40'(pv_data_a), 40'(ma[pv_addr][31:0]));
        chk({phase, " R4 pv B"}, 40'(pv_data_b), 40'(mb[pv_addr][31:0]));
      end
      chk({phase, " R3 rd0 perr"}, 40'(rd0_perr), 40'(exp_perr(rd0_addr)));
      chk({phase, " R3 rd1 perr"}, 40'(rd1_perr), 40'(exp_perr(rd1_addr)));
      chk({phase, " R7 unc"}, 40'(unc_o), 40'(eu));
      if (eu) chk({phase, " R7 unc_idx"}, 40'(unc_idx), 40'(pidx));
    end
  end

  task automatic cyc();
    @(negedge clk); #1;
  endtask
  task automatic idle();
    wr_en = 0; rep_start = 0; flip_en = 0;
  endtask
  task automatic do_write(logic [4:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; dv[a] = d; cyc(); idle();
  endtask
  task automatic do_flip(logic c, logic [4:0] a, logic [5:0] b);
    flip_en = 1; flip_copy = c; flip_addr = a; flip_bit = b; cyc(); idle();
  endtask
  task automatic peek(logic [4:0] a);
    rd0_addr = a; #1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    chk_on = 1;
    // R2: after reset every entry reads no parity error
    peek(5'd0); chk("R2 reset perr", 40'(rd0_perr), 40'd0);
    chk("R2 reset unc", 40'(unc_o), 40'd0);
    // R9: repair of an invalid entry does nothing
    phase = "R9";
    rep_start = 1; rep_addr = 3; cyc(); idle();
    chk("R9 no unc", 40'(unc_o), 40'd0);
    cyc();
    peek(5'd3); chk("R9 perr", 40'(rd0_perr), 40'd0);
    // R1: fill both copies
    phase = "R1";
    for (int e = 0; e < 32; e++) begin
      rd1_addr = 5'(e - 1); pv_addr = 5'(e + 7);
      do_write(5'(e), $urandom());
    end
    peek(5'd17); chk("R1 data A", 40'(rd0_data_a), 40'(dv[17]));
    chk("R1 data B", 40'(rd0_data_b), 40'(dv[17]));
    chk("R2 valid perr", 40'(rd0_perr), 40'd0);
    // R4: preview shows old value in the write cycle
    phase = "R4";
    pv_addr = 5; wr_en = 1; wr_addr = 5; wr_data = 32'h0BAD_F00D;
    #1 chk("R4 old value", 40'(pv_data_a), 40'(dv[5]));
    dv[5] = 32'h0BAD_F00D; cyc(); idle();
    chk("R4 new value", 40'(pv_data_b), 40'h0BAD_F00D);
    // R11, R3: parity-bit upsets
    phase = "R11";
    do_flip(1'b0, 5'd13, 6'd32);
    do_flip(1'b1, 5'd14, 6'd35);
    peek(5'd13); chk("R11 R3 A parity", 40'(rd0_perr), 40'd1);
    chk("R11 data untouched", 40'(rd0_data_a), 40'(dv[13]));
    peek(5'd14); chk("R11 R3 B parity", 40'(rd0_perr), 40'd2);
    // R5: single repair per copy direction
    phase = "R5";
    rep_start = 1; rep_addr = 13; cyc(); idle(); cyc();
    rep_start = 1; rep_addr = 14; cyc(); idle(); cyc();
    peek(5'd13); chk("R5 fixed A", 40'(rd0_perr), 40'd0);
    peek(5'd14); chk("R5 fixed B", 40'(rd0_perr), 40'd0);
    do_flip(1'b1, 5'd20, 6'd6);
    rep_start = 1; rep_addr = 20; cyc(); idle(); cyc();
    peek(5'd20); chk("R5 data B", 40'(rd0_data_b), 40'(dv[20]));
    // R6: mixed direction within one entry
    phase = "R6";
    do_write(5'd7, 32'hCAFE_1234);
    do_flip(1'b0, 5'd7, 6'd1);
    do_flip(1'b1, 5'd7, 6'd13);
    peek(5'd7); chk("R6 R3 both copies bad", 40'(rd0_perr), 40'd3);
    rep_start = 1; rep_addr = 7; cyc(); idle(); cyc();
    peek(5'd7); chk("R6 data A", 40'(rd0_data_a), 40'hCAFE_1234);
    chk("R6 data B", 40'(rd0_data_b), 40'hCAFE_1234);
    chk("R6 perr", 40'(rd0_perr), 40'd0);
    // R7: same group bad in both copies
    phase = "R7";
    do_write(5'd9, 32'h1357_9BDF);
    do_flip(1'b0, 5'd9, 6'd9);
    do_flip(1'b1, 5'd9, 6'd10);
    rep_start = 1; rep_addr = 9; cyc(); idle();
    chk("R7 unc pulse", 40'(unc_o), 40'd1);
    chk("R7 unc idx", 40'(unc_idx), 40'd9);
    cyc();
    chk("R7 pulse ends", 40'(unc_o), 40'd0);
    peek(5'd9); chk("R7 A unmodified", 40'(rd0_data_a), 40'(32'h1357_9BDF ^ 32'h200));
    chk("R7 B unmodified", 40'(rd0_data_b), 40'(32'h1357_9BDF ^ 32'h400));
    do_write(5'd9, 32'h1357_9BDF);
    // R8: writes collide with a repair
    phase = "R8";
    do_flip(1'b0, 5'd11, 6'd0);
    rep_start = 1; rep_addr = 11; wr_en = 1; wr_addr = 11; wr_data = 32'hAAAA_5555;
    dv[11] = 32'hAAAA_5555; cyc(); idle(); cyc();
    peek(5'd11); chk("R8 start-cycle write kept", 40'(rd0_data_a), 40'hAAAA_5555);
    do_flip(1'b0, 5'd11, 6'd0);
    rep_start = 1; rep_addr = 11; cyc(); idle();
    wr_en = 1; wr_addr = 11; wr_data = 32'h1234_8765; dv[11] = 32'h1234_8765;
    cyc(); idle();
    peek(5'd11); chk("R8 write-back-cycle write kept", 40'(rd0_data_b), 40'h1234_8765);
    chk("R8 perr", 40'(rd0_perr), 40'd0);
    // R10: back-to-back repair sweep
    phase = "R10";
    for (int e = 0; e < 32; e++)
      do_flip(1'(e % 2), 5'(e), 6'((e * 5) % 40));
    for (int e = 0; e < 32; e++) begin
      rep_start = 1; rep_addr = 5'(e); cyc();
    end
    idle(); cyc();
    for (int e = 0; e < 32; e++) begin
      peek(5'(e)); chk("R10 sweep perr", 40'(rd0_perr), 40'd0);
      chk("R10 sweep data", 40'(rd0_data_a), 40'(dv[e]));
    end
    // random mix compared against the model
    phase = "R5 random";
    for (int i = 0; i < 3000; i++) begin
      wr_en = ($urandom() % 10) == 0; wr_addr = 5'($urandom()); wr_data = $urandom();
      flip_en = ($urandom() % 8) == 0; flip_copy = 1'($urandom());
      flip_addr = 5'($urandom()); flip_bit = 6'($urandom() % 44);
      rep_start = ($urandom() % 3) == 0; rep_addr = 5'($urandom());
      rd0_addr = 5'($urandom()); rd1_addr = 5'($urandom()); pv_addr = 5'($urandom());
      cyc();
    end
    idle(); cyc(); cyc();
    finish_run();
  end
endmodule